// File: doc/BRIEF.md
# Vector Channel Width/Depth Packer

This block sits on one board of a pattern generator/acquirer, between a vector memory whose words are as wide as the channel port and the channel port itself. It lets the board trade channel count for vector depth. In full mode every memory word is one vector step across all channels. In half mode each word carries two steps of half the channels. In quarter mode each word carries four steps of a quarter of the channels. The step counter reports a depth limit that grows by the same factor.

The board has a single direction. When it is set to output, each step reads a memory word, selects the current sub-word and registers it onto the low channels of the port. The channel drivers are enabled in groups of eight. A disabled group, or a group above the active width, is left at high impedance. When the board is set to input, each step captures the low channels into the current sub-word slot of an assembly register. Once the last slot is filled, the full word is written to memory. Direction and packing mode can be written only while the board is idle. A write made while running is dropped.

The data path has no valid/ready handshake, because back-pressure is not possible here. A vector step is a timing event (`step` while `run`), and the block acts on it in the same cycle. Memory reads are combinational: `mem_rdata` must return the word at `mem_addr` within the cycle. A write is a one-cycle `mem_we` pulse that the memory must accept unconditionally. The group enables, the run flag and the configuration strobes are plain level or strobe controls.

Top module: `vpack_top`

## Requirements
- R1: After reset the board is set to input, the mode is full width and `depth_steps` equals the memory word count. `pin_out`, `pin_oe` and `mem_we` are all zero.
- R2: `dir_wr` loads `dir_sel` (1 = output, 0 = input) only in a cycle where `run` is low. A `dir_wr` while `run` is high leaves the direction unchanged.
- R3: `mode_wr` loads `mode_sel` (00 = full, 01 = half, 10 = quarter) only while `run` is low. The code 11 is never taken, and any `mode_wr` while running is dropped.
- R4: `depth_steps` equals the memory word count times 1, 2 or 4 for full, half or quarter mode.
- R5: In full output mode, each accepted step registers the whole word at the current address onto `pin_out`, and the address advances by one word per step.
- R6: In half or quarter output mode, each accepted step places sub-word k (bits k*L to k*L+L-1, with L = 16 or 8) on `pin_out[L-1:0]` and zeros above, starting with k = 0. The address advances only after the last sub-word of a word.
- R7: The step counter runs from 0 to `depth_steps`-1 and wraps to 0. It returns to 0, and `mem_addr` to 0, whenever `run` is low.
- R8: `pin_oe[g]` is high only when the board is set to output, `grp_en[g]` is high and group g lies within the active channels (4, 2 or 1 groups from the bottom). In input mode all of `pin_oe` is zero, whatever `grp_en` holds.
- R9: In input mode each accepted step stores `pin_in[L-1:0]` into sub-word slot k. The step that fills the last slot produces, in the next cycle, a one-cycle `mem_we` with the assembled word on `mem_wdata` and that word's address on `mem_addr`.
- R10: A `step` while `run` is low is ignored: `pin_out` holds its value, no write is issued and the partial assembly is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Board running; locks configuration |
| step | input | 1 | Vector step strobe, acted on while running |
| dir_wr | input | 1 | Direction write strobe |
| dir_sel | input | 1 | Direction to write, 1 = output |
| mode_wr | input | 1 | Packing mode write strobe |
| mode_sel | input | 2 | Packing mode to write |
| grp_en | input | CH/GRP | Per-group output enable |
| mem_addr | output | ADDR_W | Memory word address (write address during `mem_we`) |
| mem_rdata | input | CH | Memory read data for `mem_addr` |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | CH | Memory write data |
| pin_in | input | CH | Sampled channel values |
| pin_out | output | CH | Channel drive values |
| pin_oe | output | CH/GRP | Per-group driver enable, 0 = high impedance |
| depth_steps | output | ADDR_W+3 | Step depth limit for the current mode |

## Verification
The bench builds the block with an 8-word memory (ADDR_W = 3), 32 channels and 8-channel groups. The step counter therefore wraps after 8, 16 or 32 steps, and every random run segment crosses several wraps and word boundaries in each mode. With four groups, every combination of group enables and active width meets the enable logic, including groups that are enabled but lie above the active width in packed modes.

// File: rtl/vpack_pkg.sv
package vpack_pkg;

  typedef enum logic [1:0] {
    PK_FULL  = 2'b00,
    PK_HALF  = 2'b01,
    PK_QUART = 2'b10
  } pack_mode_e;

  // log2 of the packing factor
  function automatic logic [1:0] pk_shift(input pack_mode_e m);
    unique case (m)
      PK_HALF:  return 2'd1;
      PK_QUART: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

  // sub-word index mask for the packing factor
  function automatic logic [1:0] pk_mask(input pack_mode_e m);
    unique case (m)
      PK_HALF:  return 2'b01;
      PK_QUART: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/vpack_ctrl.sv
module vpack_ctrl
  import vpack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       dir_wr,
  input  logic       dir_sel,
  input  logic       mode_wr,
  input  logic [1:0] mode_sel,
  output logic       dir_out,
  output pack_mode_e mode_q
);

  logic mode_ok;
  assign mode_ok = (mode_sel != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_out <= 1'b0;
      mode_q  <= PK_FULL;
    end else if (!run) begin
      if (dir_wr)             dir_out <= dir_sel;
      if (mode_wr && mode_ok) mode_q  <= pack_mode_e'(mode_sel);
    end
  end

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(dir_out)); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(mode_q)); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11); // R3

endmodule

// File: rtl/vpack_stepper.sv
module vpack_stepper
  import vpack_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  pack_mode_e        mode,
  output logic [ADDR_W-1:0] word_addr,
  output logic [1:0]        sub_idx,
  output logic              last_sub,
  output logic [ADDR_W+2:0] depth_steps
);

  localparam int CW = ADDR_W + 2;
  localparam int DW = ADDR_W + 3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;
  logic [1:0]    shift;
  logic [1:0]    mask;

  assign shift       = pk_shift(mode);
  assign mask        = pk_mask(mode);
  assign depth_steps = (DW'(1) << ADDR_W) << shift;
  assign limit_m1    = CW'(depth_steps - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (step)   cnt <= (cnt == limit_m1) ? '0 : cnt + CW'(1);
  end

  assign word_addr = ADDR_W'(cnt >> shift);
  assign sub_idx   = cnt[1:0] & mask;
  assign last_sub  = (sub_idx == mask);

  AST_CNT_BELOW_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < depth_steps); // R7
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R10

endmodule

// File: rtl/vpack_lanes.sv
module vpack_lanes
  import vpack_pkg::*;
#(
  parameter int CH  = 32,
  parameter int GRP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dir_out,
  input  pack_mode_e        mode,
  input  logic [1:0]        sub_idx,
  input  logic [CH-1:0]     mem_rdata,
  input  logic [CH/GRP-1:0] grp_en,
  output logic [CH-1:0]     pin_out,
  output logic [CH/GRP-1:0] pin_oe
);

  localparam int NGRP   = CH / GRP;
  localparam int LANE_H = CH / 2;
  localparam int LANE_Q = CH / 4;

  logic [CH-1:0]   slice;
  logic [NGRP-1:0] active;
  logic [1:0]      shift;

  assign shift = pk_shift(mode);

  always_comb begin
    slice = '0;
    unique case (mode)
      PK_HALF:  slice[LANE_H-1:0] = mem_rdata[int'(sub_idx[0])*LANE_H +: LANE_H];
      PK_QUART: slice[LANE_Q-1:0] = mem_rdata[int'(sub_idx)*LANE_Q +: LANE_Q];
      default:  slice = mem_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_out <= '0;
    else if (load) pin_out <= slice;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign active[g] = (g < (NGRP >> shift));
    assign pin_oe[g] = dir_out & grp_en[g] & active[g];
  end

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(pin_out)); // R10
  AST_OE_WITHIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pin_oe) <= (NGRP >> shift)); // R8

endmodule

// File: rtl/vpack_gather.sv
module vpack_gather
  import vpack_pkg::*;
#(
  parameter int CH     = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cap,
  input  logic              dir_out,
  input  pack_mode_e        mode,
  input  logic [1:0]        sub_idx,
  input  logic              last_sub,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [CH-1:0]     pin_in,
  output logic              wr_en,
  output logic [CH-1:0]     wr_data,
  output logic [ADDR_W-1:0] wr_addr
);

  localparam int LANE_H = CH / 2;
  localparam int LANE_Q = CH / 4;

  logic [CH-1:0] asm_q;
  logic [CH-1:0] merged;

  always_comb begin
    merged = asm_q;
    unique case (mode)
      PK_HALF:  merged[int'(sub_idx[0])*LANE_H +: LANE_H] = pin_in[LANE_H-1:0];
      PK_QUART: merged[int'(sub_idx)*LANE_Q +: LANE_Q]    = pin_in[LANE_Q-1:0];
      default:  merged = pin_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q   <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_addr <= '0;
    end else begin
      wr_en <= 1'b0;
      if (!run) begin
        asm_q <= '0;
      end else if (cap) begin
        if (last_sub) begin
          wr_en   <= 1'b1;
          wr_data <= merged;
          wr_addr <= word_addr;
          asm_q   <= '0;
        end else begin
          asm_q <= merged;
        end
      end
    end
  end

  AST_WE_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dir_out); // R9
  AST_WE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cap)); // R9

endmodule

// File: rtl/vpack_top.sv
module vpack_top
  import vpack_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CH     = 32,
  parameter int GRP    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic              dir_wr,
  input  logic              dir_sel,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic [CH/GRP-1:0] grp_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [CH-1:0]     mem_rdata,
  output logic              mem_we,
  output logic [CH-1:0]     mem_wdata,
  input  logic [CH-1:0]     pin_in,
  output logic [CH-1:0]     pin_out,
  output logic [CH/GRP-1:0] pin_oe,
  output logic [ADDR_W+2:0] depth_steps
);

  logic              dir_out;
  pack_mode_e        mode_q;
  logic [ADDR_W-1:0] word_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [1:0]        sub_idx;
  logic              last_sub;
  logic              step_ok;

  assign step_ok = run & step;

  vpack_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .dir_wr   (dir_wr),
    .dir_sel  (dir_sel),
    .mode_wr  (mode_wr),
    .mode_sel (mode_sel),
    .dir_out  (dir_out),
    .mode_q   (mode_q)
  );

  vpack_stepper #(.ADDR_W(ADDR_W)) u_stepper (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .step        (step),
    .mode        (mode_q),
    .word_addr   (word_addr),
    .sub_idx     (sub_idx),
    .last_sub    (last_sub),
    .depth_steps (depth_steps)
  );

  vpack_lanes #(.CH(CH), .GRP(GRP)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step_ok & dir_out),
    .dir_out   (dir_out),
    .mode      (mode_q),
    .sub_idx   (sub_idx),
    .mem_rdata (mem_rdata),
    .grp_en    (grp_en),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  vpack_gather #(.CH(CH), .ADDR_W(ADDR_W)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cap       (step_ok & ~dir_out),
    .dir_out   (dir_out),
    .mode      (mode_q),
    .sub_idx   (sub_idx),
    .last_sub  (last_sub),
    .word_addr (word_addr),
    .pin_in    (pin_in),
    .wr_en     (mem_we),
    .wr_data   (mem_wdata),
    .wr_addr   (wr_addr)
  );

  assign mem_addr = mem_we ? wr_addr : word_addr;

  AST_ADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (mem_we || mem_addr == '0)); // R7

endmodule

// File: tb/vpack_top_bench.sv
`timescale 1ns/1ps
module vpack_top_bench;

  localparam int AW = 3, CH = 32, GRP = 8, NG = CH / GRP, WORDS = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, run, step, dir_wr, dir_sel, mode_wr;
  logic [1:0]    mode_sel;
  logic [NG-1:0] grp_en;
  logic [AW-1:0] mem_addr;
  logic [CH-1:0] mem_rdata, mem_wdata, pin_in, pin_out;
  logic          mem_we;
  logic [NG-1:0] pin_oe;
  logic [AW+2:0] depth_steps;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  bit          m_dir, m_we;
  logic [1:0]  m_mode;
  int          m_cnt, m_waddr;
  logic [31:0] m_out, m_asm, m_wdata;

  function automatic logic [31:0] memword(input logic [AW-1:0] a);
    return (32'h9E3779B1 * (32'(a) + 32'd1)) ^ 32'hC3A5_0F96;
  endfunction

  assign mem_rdata = memword(mem_addr);

  vpack_top #(.ADDR_W(AW), .CH(CH), .GRP(GRP)) u_vpack_top (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .dir_wr(dir_wr),
    .dir_sel(dir_sel), .mode_wr(mode_wr), .mode_sel(mode_sel), .grp_en(grp_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .depth_steps(depth_steps)
  );

  function automatic int shf(input logic [1:0] m);
    return (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 0;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] m, input int sub);
    logic [31:0] r = '0;
    int l = CH >> shf(m);
    for (int i = 0; i < l; i++) r[i] = w[sub * l + i];
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] a, input logic [31:0] p,
                                        input logic [1:0] m, input int sub);
    logic [31:0] r = a;
    int l = CH >> shf(m);
    for (int i = 0; i < l; i++) r[sub * l + i] = p[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance the model by one clock edge using the inputs currently applied
  task automatic model_edge();
    int sh = shf(m_mode);
    int depth = WORDS << sh;
    int sub = m_cnt % (1 << sh);
    int word = m_cnt >> sh;
    bit last = (sub == (1 << sh) - 1);
    logic [31:0] mg;
    m_we = 0;
    if (!run) m_asm = '0;
    else if (step && !m_dir) begin
      mg = merge(m_asm, pin_in, m_mode, sub);
      if (last) begin m_we = 1; m_wdata = mg; m_waddr = word; m_asm = '0; end
      else m_asm = mg;
    end
    if (run && step && m_dir) m_out = pick(memword(AW'(word)), m_mode, sub);
    if (!run) m_cnt = 0;
    else if (step) m_cnt = (m_cnt == depth - 1) ? 0 : m_cnt + 1;
    if (!run) begin
      if (dir_wr) m_dir = dir_sel;
      if (mode_wr && mode_sel != 2'b11) m_mode = mode_sel;
    end
  endtask

  task automatic check_all();
    int sh = shf(m_mode);
    logic [NG-1:0] eoe;
    for (int g = 0; g < NG; g++) eoe[g] = m_dir && grp_en[g] && (g < (NG >> sh));
    chk(pin_out == m_out, (sh == 0) ? "R5 pin_out" : "R6 pin_out", 64'(pin_out), 64'(m_out));
    chk(pin_oe == eoe, "R8 pin_oe", 64'(pin_oe), 64'(eoe));
    chk(mem_we == m_we, "R9 mem_we", 64'(mem_we), 64'(m_we));
    if (m_we) begin
      chk(mem_wdata == m_wdata, "R9 mem_wdata", 64'(mem_wdata), 64'(m_wdata));
      chk(mem_addr == AW'(m_waddr), "R9 write address", 64'(mem_addr), 64'(m_waddr));
    end else begin
      chk(mem_addr == AW'(m_cnt >> sh), run ? ((sh == 0) ? "R5 address" : "R6 address") : "R7 idle address",
          64'(mem_addr), 64'(m_cnt >> sh));
    end
    chk(depth_steps == (AW+3)'(WORDS << sh), "R4 depth_steps", 64'(depth_steps), 64'(WORDS << sh));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic configure(input bit d, input logic [1:0] m);
    run = 0; dir_wr = 1; dir_sel = d; mode_wr = 1; mode_sel = m;
    cyc();
    dir_wr = 0; mode_wr = 0;
  endtask

  task automatic run_seg(input bit d, input logic [1:0] m, input int n, input int pstep);
    logic [CH-1:0] held;
    configure(d, m);
    run = 1;
    for (int k = 0; k < n; k++) begin
      step    = ($urandom % 100) < pstep;
      pin_in  = $urandom;
      grp_en  = NG'($urandom);
      dir_wr  = ($urandom % 12) == 0;
      dir_sel = $urandom % 2;
      mode_wr = ($urandom % 12) == 0;
      mode_sel = 2'($urandom);
      cyc();
    end
    dir_wr = 0; mode_wr = 0; run = 0; step = 1;
    cyc();
    held = pin_out;
    for (int k = 0; k < 3; k++) begin
      pin_in = $urandom;
      cyc();
      chk(pin_out == held && !mem_we, "R10 idle step", 64'({mem_we, pin_out}), 64'(held));
    end
    step = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; run = 0; step = 0; dir_wr = 0; dir_sel = 0; mode_wr = 0;
    mode_sel = 0; grp_en = '1; pin_in = '0;
    m_dir = 0; m_we = 0; m_mode = 0; m_cnt = 0; m_waddr = 0;
    m_out = '0; m_asm = '0; m_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(pin_out == '0, "R1 pin_out", 64'(pin_out), 0);
    chk(pin_oe == '0, "R1 pin_oe input dir", 64'(pin_oe), 0);
    chk(mem_we == 0, "R1 mem_we", 64'(mem_we), 0);
    chk(depth_steps == (AW+3)'(WORDS), "R1 depth full", 64'(depth_steps), WORDS);
    cyc();

    // random segments over every direction and mode
    for (int rep = 0; rep < 3; rep++) begin
      for (int d = 1; d >= 0; d--) begin
        for (int m = 0; m < 3; m++) begin
          run_seg(d[0], 2'(m), 120, 40 + 20 * rep);
        end
      end
    end

    // R3: reserved code ignored while idle
    configure(1'b1, 2'b01);
    mode_wr = 1; mode_sel = 2'b11; cyc(); mode_wr = 0;
    chk(depth_steps == (AW+3)'(2 * WORDS), "R3 reserved code", 64'(depth_steps), 2 * WORDS);

    // R2/R3: writes while running are dropped
    run = 1; dir_wr = 1; dir_sel = 0; mode_wr = 1; mode_sel = 2'b10; cyc();
    dir_wr = 0; mode_wr = 0; grp_en = '1; cyc();
    chk(pin_oe == 4'b0011, "R2 direction held during run", 64'(pin_oe), 64'h3);
    chk(depth_steps == (AW+3)'(2 * WORDS), "R3 mode held during run", 64'(depth_steps), 2 * WORDS);

    // R7: full wrap in quarter mode
    configure(1'b1, 2'b10);
    run = 1; step = 1;
    for (int k = 0; k < 4 * WORDS; k++) cyc();
    chk(mem_addr == '0, "R7 wrap to word 0", 64'(mem_addr), 0);
    step = 0; cyc();
    chk(pin_out == {24'h0, memword(AW'(WORDS - 1))[31:24]}, "R6 last sub-word of last word",
        64'(pin_out), 64'(memword(AW'(WORDS - 1))[31:24]));
    run = 0; cyc();

    // R8: input direction blocks all enables
    configure(1'b0, 2'b00);
    grp_en = '1; cyc();
    chk(pin_oe == '0, "R8 input ignores grp_en", 64'(pin_oe), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule